// File: doc/BRIEF.md
# Preemptive Urgency-Reservation Crossbar Scheduler

This block picks a conflict-free set of input-to-output transfers for an N×N crossbar. The crossbar has one virtual output queue per input/output pair. A round begins when `start` is seen while the block is idle. At that point the block takes a snapshot of the N×N queue-length array. It then walks the inputs one at a time over a shared vector of per-output urgencies and owners. An input claims the output where its backlog exceeds the recorded urgency by the largest margin. It may displace an earlier claimant to do so.

A second pass over the inputs turns the claims into bookings. An input that still owns a claim books that output. An input that lost its claim falls back to an output that no input claimed, provided its own queue for that output is non-empty. The result is a registered permutation-style matrix and a one-cycle `done` pulse. The matrix stays unchanged until the next round starts.

Top module: `rsv_urgency_sched`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `match_flat` is all zero and `done` is low. A reset in the middle of a round abandons that round.
- R2: `start` is accepted only when no round is in progress. On acceptance the block keeps a copy of `qlen_flat`, where entry (i,j) sits at bits `(i*N+j)*W` and up, and is unsigned. Later changes to `qlen_flat`, and `start` pulses during a round, have no effect on that round.
- R3: In the claim pass, inputs take turns in ascending index order, one per clock. The urgencies are all zero at the start of each round. Input i computes the signed value X[i][j] minus urgency[j] for every output j and selects the largest. A tie goes to the lowest output index.
- R4: If that largest value is strictly positive, input i becomes owner of output j and urgency[j] becomes X[i][j], displacing any earlier owner. Otherwise the claim vector is left unchanged. A full-scale queue length (2^W-1) against a zero urgency is handled without overflow.
- R5: In the booking pass, inputs take turns in ascending index order. An input that still owns an output books that output.
- R6: An input that owns nothing books the lowest-index output that is unclaimed, not yet booked in this round, and for which the input's queue length is non-zero. If no such output exists, the input books nothing.
- R7: Bit `i*N+j` of `match_flat` set means input i sends to output j. Each row and each column has at most one bit set.
- R8: `done` is high for exactly one cycle. Its rising edge comes 2N rising clock edges after the edge that accepted `start`, and `match_flat` then holds the round's final result. That result stays unchanged until the next accepted `start`, which clears it on the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a round (taken only when idle) |
| qlen_flat | input | N*N*W | Queue lengths, entry (i,j) at bits (i*N+j)*W |
| match_flat | output | N*N | Booking matrix, bit i*N+j = input i to output j |
| done | output | 1 | One-cycle pulse when the matrix is final |

## Verification
The bench builds the block with N=4 and W=4. Queue lengths therefore reach full scale (15) in a single nibble, and a whole 4×4 stimulus fits one 64-bit table word. Four ports make room for chains of displacement: one output is taken over twice in one round. There are also cases where two displaced inputs compete for the same unclaimed output, and ties between equal margins at several positions. The small W lets the saturating all-15 matrix test the signed margin at its widest span, alongside zero and negative margins.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RESV = 2'd1,
    PH_ACK  = 2'd2
  } phase_t;
endpackage

// File: rtl/rsv_qstore.sv
// Round snapshot of queue lengths, one wide word per input row.
module rsv_qstore #(
  parameter int N = 4,
  parameter int W = 8,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1,
  localparam int ROWW = N * W
) (
  input  logic              clk,
  input  logic              load,
  input  logic [N*ROWW-1:0] qlen_flat,
  input  logic [IDXW-1:0]   rd_row,
  output logic [ROWW-1:0]   row
);
  logic [ROWW-1:0] mem [N];

  for (genvar i = 0; i < N; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (load) mem[i] <= qlen_flat[i*ROWW +: ROWW];
    end
  end

  assign row = mem[rd_row];
endmodule

// File: rtl/rsv_argmax.sv
// Largest signed margin (queue length minus urgency), lowest index on ties.
module rsv_argmax #(
  parameter int N = 4,
  parameter int W = 8,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*W-1:0]  xrow,
  input  logic [N*W-1:0]  urg,
  output logic [IDXW-1:0] best_idx,
  output logic            best_pos
);
  logic signed [W:0] margin [N];
  logic signed [W:0] best_val;

  for (genvar j = 0; j < N; j++) begin : g_margin
    assign margin[j] = $signed({1'b0, xrow[j*W +: W]}) - $signed({1'b0, urg[j*W +: W]});
  end

  always_comb begin
    best_idx = '0;
    best_val = margin[0];
    for (int j = 1; j < N; j++) begin
      if (margin[j] > best_val) begin
        best_val = margin[j];
        best_idx = IDXW'(j);
      end
    end
    best_pos = (best_val > $signed({(W+1){1'b0}}));
  end
endmodule

// File: rtl/rsv_fill_pick.sv
// Booking choice: owned output first, else lowest free non-empty output.
module rsv_fill_pick #(
  parameter int N = 4,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    owned,
  input  logic [N-1:0]    nz,
  input  logic [N-1:0]    rsv_valid,
  input  logic [N-1:0]    booked,
  output logic [IDXW-1:0] pick_idx,
  output logic            pick_ok
);
  logic [N-1:0] cand;
  assign cand = nz & ~rsv_valid & ~booked;

  always_comb begin
    pick_idx = '0;
    pick_ok  = 1'b0;
    if (|owned) begin
      for (int j = 0; j < N; j++) begin
        if (owned[j]) begin
          pick_idx = IDXW'(j);
          pick_ok  = 1'b1;
        end
      end
    end else begin
      for (int j = N - 1; j >= 0; j--) begin
        if (cand[j]) begin
          pick_idx = IDXW'(j);
          pick_ok  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rsv_urgency_sched.sv
module rsv_urgency_sched
  import rsv_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [N*N*W-1:0] qlen_flat,
  output logic [N*N-1:0]   match_flat,
  output logic             done
);
  localparam int IDXW = (N > 1) ? $clog2(N) : 1;
  localparam int ROWW = N * W;

  phase_t          st;
  logic [IDXW-1:0] idx;
  logic [ROWW-1:0] urg_flat;
  logic [N-1:0]    rsv_valid;
  logic [N-1:0]    booked;
  logic [IDXW-1:0] owner [N];
  logic [ROWW-1:0] cur_row;
  logic [IDXW-1:0] best_idx;
  logic            best_pos;
  logic [N-1:0]    nz_row;
  logic [N-1:0]    owned;
  logic [IDXW-1:0] pick_idx;
  logic            pick_ok;
  logic            accept;
  logic            last_step;

  assign accept    = (st == PH_IDLE) && start;
  assign last_step = (idx == IDXW'(N - 1));

  rsv_qstore #(.N(N), .W(W)) u_store (
    .clk      (clk),
    .load     (accept),
    .qlen_flat(qlen_flat),
    .rd_row   (idx),
    .row      (cur_row)
  );

  rsv_argmax #(.N(N), .W(W)) u_argmax (
    .xrow    (cur_row),
    .urg     (urg_flat),
    .best_idx(best_idx),
    .best_pos(best_pos)
  );

  for (genvar j = 0; j < N; j++) begin : g_col
    assign nz_row[j] = |cur_row[j*W +: W];
    assign owned[j]  = rsv_valid[j] && (owner[j] == idx);
  end

  rsv_fill_pick #(.N(N)) u_pick (
    .owned    (owned),
    .nz       (nz_row),
    .rsv_valid(rsv_valid),
    .booked   (booked),
    .pick_idx (pick_idx),
    .pick_ok  (pick_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= PH_IDLE;
      idx        <= '0;
      urg_flat   <= '0;
      rsv_valid  <= '0;
      booked     <= '0;
      match_flat <= '0;
      done       <= 1'b0;
      for (int j = 0; j < N; j++) owner[j] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        PH_IDLE: begin
          if (start) begin
            st         <= PH_RESV;
            idx        <= '0;
            urg_flat   <= '0;
            rsv_valid  <= '0;
            booked     <= '0;
            match_flat <= '0;
          end
        end
        PH_RESV: begin
          if (best_pos) begin
            urg_flat[best_idx*W +: W] <= cur_row[best_idx*W +: W];
            rsv_valid[best_idx]       <= 1'b1;
            owner[best_idx]           <= idx;
          end
          if (last_step) begin
            st  <= PH_ACK;
            idx <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        PH_ACK: begin
          if (pick_ok) begin
            match_flat[idx*N + pick_idx] <= 1'b1;
            booked[pick_idx]             <= 1'b1;
          end
          if (last_step) begin
            st   <= PH_IDLE;
            idx  <= '0;
            done <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rsv_urgency_sched_chk.sv
module rsv_urgency_sched_chk
  import rsv_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             done,
  input logic [N*N-1:0]   match_flat,
  input phase_t           st,
  input logic [N*W-1:0]   urg_flat
);
  localparam int CW = $clog2(2 * N + 2) + 1;

  logic          run;
  logic [CW-1:0] since;
  logic          shape_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      since <= '0;
    end else if (st == PH_IDLE && start) begin
      run   <= 1'b1;
      since <= '0;
    end else if (done) begin
      run <= 1'b0;
    end else if (run) begin
      since <= since + 1'b1;
    end
  end

  always_comb begin
    shape_bad = 1'b0;
    for (int i = 0; i < N; i++) begin
      if ($countones(match_flat[i*N +: N]) > 1) shape_bad = 1'b1;
    end
    for (int j = 0; j < N; j++) begin
      int c;
      c = 0;
      for (int i = 0; i < N; i++) c += int'(match_flat[i*N + j]);
      if (c > 1) shape_bad = 1'b1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (match_flat == '0 && !done));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_latency_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (run && since == CW'(2 * N)));

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (st == PH_IDLE && !start) |=> $stable(match_flat));

  assert_one_per_row_col_R7: assert property (@(posedge clk) disable iff (rst)
    !shape_bad);

  for (genvar j = 0; j < N; j++) begin : g_urg
    assert_urgency_rises_R4: assert property (@(posedge clk) disable iff (rst)
      (st == PH_RESV) |=> (urg_flat[j*W +: W] >= $past(urg_flat[j*W +: W])));
  end
endmodule

bind rsv_urgency_sched rsv_urgency_sched_chk #(.N(N), .W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .done      (done),
  .match_flat(match_flat),
  .st        (st),
  .urg_flat  (urg_flat)
);

// File: tb/rsv_urgency_sched_test.sv
`timescale 1ns/1ps
module rsv_urgency_sched_test;
  localparam int N = 4;
  localparam int W = 4;
  localparam int NV = 8;

  // Entry (i,j) is nibble i*4+j; expected bit i*4+j = input i to output j.
  localparam logic [63:0] VEC_Q [NV] = '{
    64'h5000_0500_0050_0005,  // diagonal, no contention
    64'h0000_0000_0027_0003,  // input1 displaces input0, no fallback
    64'h0000_0000_0006_0024,  // displaced input0 falls back to output1
    64'h0300_3300_0050_0550,  // ties -> lowest index; zero margin claims nothing
    64'h0000_0009_0104_0103,  // double displacement, fallback conflict
    64'h0000_0000_0000_0000,  // empty
    64'hFFFF_FFFF_FFFF_FFFF,  // full scale
    64'h0000_0000_0005_1101   // fallback chooses lowest of two free outputs
  };
  localparam logic [15:0] VEC_M [NV] = '{
    16'h8421, 16'h0010, 16'h0012, 16'h0402,
    16'h0104, 16'h0000, 16'h8421, 16'h0014
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [N*N*W-1:0] qlen_flat = '0;
  logic [N*N-1:0]   match_flat;
  logic             done;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  rsv_urgency_sched #(.N(N), .W(W)) uut (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .qlen_flat (qlen_flat),
    .match_flat(match_flat),
    .done      (done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drives start for one cycle and returns the number of negedges until done.
  task automatic run_round(input logic [63:0] q, output int lat);
    @(negedge clk);
    qlen_flat = q;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 4 * N + 10) begin
      @(negedge clk);
      lat++;
    end
  endtask

  function automatic bit shape_ok(input logic [15:0] m);
    for (int i = 0; i < N; i++) begin
      int r, c;
      r = 0; c = 0;
      for (int j = 0; j < N; j++) begin
        r += int'(m[i*N + j]);
        c += int'(m[j*N + i]);
      end
      if (r > 1 || c > 1) return 1'b0;
    end
    return 1'b1;
  endfunction

  initial begin
    #(200000 * 5);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int lat;
    logic [15:0] held;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(match_flat == '0, "R1", "match in reset", 64'(match_flat), 64'h0);
    check(done == 1'b0, "R1", "done in reset", 64'(done), 64'h0);
    rst = 1'b0;
    @(negedge clk);
    check(match_flat == '0 && !done, "R1", "after reset", 64'(match_flat), 64'h0);

    // Table walk: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      run_round(VEC_Q[v], lat);
      // done rises 2N edges after the accepting edge -> negedge 2N+1
      check(lat == 2 * N + 1, "R8", $sformatf("done latency vec%0d", v),
            64'(lat), 64'(2 * N + 1));
      check(match_flat == VEC_M[v], "R3 R4 R5 R6",
            $sformatf("match vec%0d", v), 64'(match_flat), 64'(VEC_M[v]));
      check(shape_ok(match_flat), "R7", $sformatf("one per row/col vec%0d", v),
            64'(match_flat), 64'(VEC_M[v]));
    end

    // R8: done is a single pulse and the result holds while idle
    held = match_flat;
    @(negedge clk);
    check(done == 1'b0, "R8", "done single cycle", 64'(done), 64'h0);
    qlen_flat = 64'h1234_5678_9ABC_DEF0;
    repeat (4) @(negedge clk);
    check(match_flat == held, "R8", "match held while idle", 64'(match_flat), 64'(held));

    // R2: start pulses and input changes during a round are ignored
    @(negedge clk);
    qlen_flat = VEC_Q[1];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    qlen_flat = VEC_Q[6];
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 3;
    while (!done && lat < 4 * N + 10) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 2 * N + 1, "R2", "latency with busy start", 64'(lat), 64'(2 * N + 1));
    check(match_flat == VEC_M[1], "R2", "snapshot kept", 64'(match_flat), 64'(VEC_M[1]));
    repeat (2) @(negedge clk);
    check(match_flat == VEC_M[1], "R2", "busy start did not queue a round",
          64'(match_flat), 64'(VEC_M[1]));

    // R8: an accepted start clears the previous result on its edge
    qlen_flat = VEC_Q[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(match_flat == '0, "R8", "cleared on accept", 64'(match_flat), 64'h0);

    // R1: reset in the middle of a round
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(match_flat == '0 && !done, "R1", "mid-round reset", 64'(match_flat), 64'h0);
    repeat (2 * N + 2) @(negedge clk);
    check(done == 1'b0 && match_flat == '0, "R1", "abandoned round stays idle",
          64'(match_flat), 64'h0);

    // R6: round after reset still works (fallback case)
    run_round(VEC_Q[2], lat);
    check(match_flat == VEC_M[2], "R6", "fallback after reset", 64'(match_flat), 64'(VEC_M[2]));

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule